// File: doc/BRIEF.md
# Overlapping Register Window File

This block is the integer register file of a core that gives every procedure call its own set of registers. Software always addresses 32 registers. Eight of them are shared by all procedures. The other 24 belong to the current window, as 8 locals, 8 inputs and 8 outputs. A save command moves to a fresh window for a callee, and a restore command returns to the caller's window. The windows overlap: the registers the caller writes as outputs are the same storage the callee reads as inputs, so arguments and return values pass between procedures without any copying.

On chip, the window storage is a ring of `NFRAMES` physical slots, where `NFRAMES` is between 4 and 8 and defaults to 4. Each slot holds the locals and inputs of one window. The outputs of the current window live in the input half of the slot that follows it. Because of this, the ring can hold at most `NFRAMES-1` windows at once. When a save finds the ring full, the block first copies the oldest resident window out to memory. When a restore finds that the caller's window is not on chip, the block first loads that window back from memory. During either transfer the stall output is high, and the command finishes only after the last word has moved. Memory is used as a downward-growing stack of 16-word frames.

The read ports are combinational. The write port and the two commands are sampled on the rising clock edge.

Top module: `win_regfile`

## Requirements
- R1: The register number selects one of four groups of 8 registers. Registers 0-7 are shared. Registers 8-15 are the current window's locals. Registers 16-23 are its inputs. Registers 24-31 are its outputs. Reads return data in the same cycle. A write becomes visible to reads in the cycle after its clock edge.
- R2: Register 0 always reads as zero. Writes to register 0 are discarded.
- R3: Registers 1-7 hold their values across any number of saves and restores, including those that spill or fill.
- R4: When a free slot exists, a save completes at its clock edge and raises no stall. After the save, the new inputs hold the values the old outputs had, and the new locals and the new outputs read as zero.
- R5: A restore returns the caller's locals and inputs exactly as the caller left them. The caller's outputs then hold the callee's inputs as they were at the time of the restore. The locals of the window being left are cleared.
- R6: A save issued while `NFRAMES-1` windows are resident first spills the oldest resident window as 16 writes. Local k goes to address base+k and input k goes to address base+8+k, where base is the stack pointer minus 16. The stack pointer, which starts at `SP_TOP`, then drops by 16.
- R7: A restore issued while only the current window is resident first fills the caller's window with 16 reads. The reads start at the stack pointer and use the same layout as a spill. The stack pointer then rises by 16.
- R8: Each transfer word is one `mem_req`/`mem_ack` handshake. `mem_we` is 1 for a spill and 0 for a fill. While `mem_req` is high and `mem_ack` is low, the address, direction and write data stay stable. One word moves on each clock edge where `mem_req` and `mem_ack` are both high.
- R9: `stall` rises in the cycle after a save or restore that needs a transfer. It falls in the cycle after the edge that accepts the last word, and the window change is visible in that same cycle. While `stall` is high, writes, saves and restores are ignored. If save and restore are asserted together, the save is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rs1_addr | input | 5 | Read port 1 register number |
| rs1_data | output | XLEN | Read port 1 data |
| rs2_addr | input | 5 | Read port 2 register number |
| rs2_data | output | XLEN | Read port 2 data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write register number |
| wr_data | input | XLEN | Write data |
| save_req | input | 1 | Move to a new callee window |
| restore_req | input | 1 | Return to the caller window |
| stall | output | 1 | Spill or fill in progress; commands and writes ignored |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = spill write, 0 = fill read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | XLEN | Spill data |
| mem_ack | input | 1 | Memory accepts the current word |
| mem_rdata | input | XLEN | Fill data, valid with `mem_ack` |

## Verification
Read data is due in the same cycle as the address, so the bench reads all 32 registers only between clock edges, while the block is idle. A write, or a save or restore that needs no transfer, shows its effect one edge later, and the bench samples it at the next falling edge. For a transfer, the bench checks that `stall` is high at the first falling edge after the command. It records the cycle in which the last word is acknowledged and requires `stall` to be low exactly one cycle after that cycle. Only then does it compare the registers, the memory image and the transfer word count against its own model of a stack of windows.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

    localparam int unsigned GROUP_REGS  = 8;
    localparam int unsigned FRAME_WORDS = 16;

    typedef enum logic [1:0] {
        GRP_SHARED = 2'd0,
        GRP_LOCAL  = 2'd1,
        GRP_IN     = 2'd2,
        GRP_OUT    = 2'd3
    } reg_group_e;

    typedef enum logic {
        DIR_SPILL = 1'b0,
        DIR_FILL  = 1'b1
    } xfer_dir_e;

endpackage

// File: rtl/wrf_map.sv
module wrf_map
    import wrf_pkg::*;
#(
    parameter  int unsigned NFRAMES = 4,
    localparam int unsigned SLOTW   = $clog2(NFRAMES),
    localparam int unsigned IW      = SLOTW + 4
) (
    input  logic [4:0]       arch_reg,
    input  logic [SLOTW-1:0] cwp,
    output logic             is_shared,
    output logic             is_zero,
    output logic [IW-1:0]    phys_idx
);

    reg_group_e       grp;
    logic [SLOTW-1:0] next_slot;

    always_comb begin
        grp       = reg_group_e'(arch_reg[4:3]);
        next_slot = (cwp == SLOTW'(NFRAMES - 1)) ? '0 : cwp + SLOTW'(1);
        is_shared = (grp == GRP_SHARED);
        is_zero   = (arch_reg == 5'd0);
        unique case (grp)
            GRP_OUT: phys_idx = {next_slot, 1'b1, arch_reg[2:0]};
            GRP_IN:  phys_idx = {cwp, 1'b1, arch_reg[2:0]};
            default: phys_idx = {cwp, 1'b0, arch_reg[2:0]};
        endcase
    end

endmodule

// File: rtl/wrf_xfer.sv
module wrf_xfer
    import wrf_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  xfer_dir_e     start_dir,
    input  logic [AW-1:0] start_base,
    input  logic          mem_ack,
    output logic          busy,
    output logic [3:0]    idx,
    output xfer_dir_e     dir,
    output logic          beat,
    output logic          done,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr
);

    typedef struct packed {
        logic          busy;
        logic [3:0]    idx;
        xfer_dir_e     dir;
        logic [AW-1:0] base;
    } xfer_t;

    xfer_t x_d, x_q;

    always_comb begin
        x_d = x_q;
        if (!x_q.busy) begin
            if (start) begin
                x_d.busy = 1'b1;
                x_d.idx  = 4'd0;
                x_d.dir  = start_dir;
                x_d.base = start_base;
            end
        end else if (mem_ack) begin
            if (x_q.idx == 4'(FRAME_WORDS - 1)) begin
                x_d.busy = 1'b0;
            end else begin
                x_d.idx = x_q.idx + 4'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q <= '{busy: 1'b0, idx: 4'd0, dir: DIR_SPILL, base: '0};
        end else begin
            x_q <= x_d;
        end
    end

    assign busy     = x_q.busy;
    assign idx      = x_q.idx;
    assign dir      = x_q.dir;
    assign beat     = x_q.busy && mem_ack;
    assign done     = beat && (x_q.idx == 4'(FRAME_WORDS - 1));
    assign mem_req  = x_q.busy;
    assign mem_we   = x_q.busy && (x_q.dir == DIR_SPILL);
    assign mem_addr = x_q.base + AW'(x_q.idx);

    // R8: a pending request keeps its address and direction until accepted
    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R9: a new transfer is only launched from idle
    p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

endmodule

// File: rtl/win_regfile.sv
module win_regfile
    import wrf_pkg::*;
#(
    parameter int unsigned   XLEN    = 32,
    parameter int unsigned   NFRAMES = 4,
    parameter int unsigned   AW      = 16,
    parameter logic [AW-1:0] SP_TOP  = AW'(1024)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [4:0]      rs1_addr,
    output logic [XLEN-1:0] rs1_data,
    input  logic [4:0]      rs2_addr,
    output logic [XLEN-1:0] rs2_data,
    input  logic            wr_en,
    input  logic [4:0]      wr_addr,
    input  logic [XLEN-1:0] wr_data,
    input  logic            save_req,
    input  logic            restore_req,
    output logic            stall,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic            mem_ack,
    input  logic [XLEN-1:0] mem_rdata
);

    localparam int unsigned SLOTW  = $clog2(NFRAMES);
    localparam int unsigned IW     = SLOTW + 4;
    localparam int unsigned DEPTH  = NFRAMES * FRAME_WORDS;
    localparam int unsigned MAXRES = NFRAMES - 1;
    localparam int unsigned NPORTS = 3;

    typedef struct packed {
        logic [SLOTW-1:0] cwp;
        logic [SLOTW-1:0] res;
        logic [AW-1:0]    sp;
        logic             pend_save;
    } win_t;

    win_t            st_d, st_q;
    logic [XLEN-1:0] phys_d [DEPTH];
    logic [XLEN-1:0] phys_q [DEPTH];
    logic [XLEN-1:0] glob_d [GROUP_REGS];
    logic [XLEN-1:0] glob_q [GROUP_REGS];

    function automatic logic [SLOTW-1:0] slot_inc(input logic [SLOTW-1:0] s);
        return (s == SLOTW'(NFRAMES - 1)) ? '0 : s + SLOTW'(1);
    endfunction

    function automatic logic [SLOTW-1:0] slot_dec(input logic [SLOTW-1:0] s);
        return (s == '0) ? SLOTW'(NFRAMES - 1) : s - SLOTW'(1);
    endfunction

    // Register number to physical slot mapping, one per port (R1)
    logic [4:0]    map_reg    [NPORTS];
    logic          map_shared [NPORTS];
    logic          map_zero   [NPORTS];
    logic [IW-1:0] map_idx    [NPORTS];

    assign map_reg[0] = rs1_addr;
    assign map_reg[1] = rs2_addr;
    assign map_reg[2] = wr_addr;

    for (genvar g = 0; g < NPORTS; g++) begin : g_map
        wrf_map #(.NFRAMES(NFRAMES)) u_map (
            .arch_reg (map_reg[g]),
            .cwp      (st_q.cwp),
            .is_shared(map_shared[g]),
            .is_zero  (map_zero[g]),
            .phys_idx (map_idx[g])
        );
    end

    // Spill and fill sequencer
    logic          busy, beat, done, start;
    logic [3:0]    xidx;
    xfer_dir_e     xdir, start_dir;
    logic [AW-1:0] start_base;

    wrf_xfer #(.AW(AW)) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_dir (start_dir),
        .start_base(start_base),
        .mem_ack   (mem_ack),
        .busy      (busy),
        .idx       (xidx),
        .dir       (xdir),
        .beat      (beat),
        .done      (done),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr)
    );

    logic [SLOTW-1:0] spill_slot, fill_slot, new_slot;

    assign spill_slot = slot_inc(slot_inc(st_q.cwp));
    assign fill_slot  = slot_dec(st_q.cwp);
    assign new_slot   = slot_inc(st_q.cwp);
    assign mem_wdata  = phys_q[{spill_slot, xidx}];
    assign stall      = busy;

    // Read ports (R1, R2)
    always_comb begin
        if (map_zero[0])        rs1_data = '0;
        else if (map_shared[0]) rs1_data = glob_q[rs1_addr[2:0]];
        else                    rs1_data = phys_q[map_idx[0]];
        if (map_zero[1])        rs2_data = '0;
        else if (map_shared[1]) rs2_data = glob_q[rs2_addr[2:0]];
        else                    rs2_data = phys_q[map_idx[1]];
    end

    logic do_save, do_restore, keep_res;

    always_comb begin
        st_d       = st_q;
        phys_d     = phys_q;
        glob_d     = glob_q;
        start      = 1'b0;
        start_dir  = DIR_SPILL;
        start_base = st_q.sp;
        do_save    = 1'b0;
        do_restore = 1'b0;
        keep_res   = 1'b0;

        if (!busy) begin
            // R2: register 0 is never written
            if (wr_en && !map_zero[2]) begin
                if (map_shared[2]) glob_d[wr_addr[2:0]] = wr_data;
                else               phys_d[map_idx[2]]   = wr_data;
            end
            if (save_req) begin
                if (st_q.res == SLOTW'(MAXRES)) begin
                    // R6: ring full, evict the oldest window first
                    start          = 1'b1;
                    start_dir      = DIR_SPILL;
                    start_base     = st_q.sp - AW'(FRAME_WORDS);
                    st_d.pend_save = 1'b1;
                end else begin
                    do_save = 1'b1;
                end
            end else if (restore_req) begin
                if (st_q.res == SLOTW'(1)) begin
                    // R7: caller not resident, bring it back first
                    start          = 1'b1;
                    start_dir      = DIR_FILL;
                    start_base     = st_q.sp;
                    st_d.pend_save = 1'b0;
                end else begin
                    do_restore = 1'b1;
                end
            end
        end else begin
            // R9: writes and commands are dropped while a transfer runs
            if (beat && (xdir == DIR_FILL)) begin
                phys_d[{fill_slot, xidx}] = mem_rdata;
            end
            if (done) begin
                keep_res = 1'b1;
                if (st_q.pend_save) begin
                    st_d.sp = st_q.sp - AW'(FRAME_WORDS);
                    do_save = 1'b1;
                end else begin
                    st_d.sp    = st_q.sp + AW'(FRAME_WORDS);
                    do_restore = 1'b1;
                end
            end
        end

        if (do_save) begin
            // R4: new locals and new outputs start cleared
            for (int k = 0; k < GROUP_REGS; k++) begin
                phys_d[{new_slot, 1'b0, 3'(k)}]           = '0;
                phys_d[{slot_inc(new_slot), 1'b1, 3'(k)}] = '0;
            end
            st_d.cwp = new_slot;
            if (!keep_res) st_d.res = st_q.res + SLOTW'(1);
        end

        if (do_restore) begin
            // R5: locals of the window being left are cleared
            for (int k = 0; k < GROUP_REGS; k++) begin
                phys_d[{st_q.cwp, 1'b0, 3'(k)}] = '0;
            end
            st_d.cwp = fill_slot;
            if (!keep_res) st_d.res = st_q.res - SLOTW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cwp: '0, res: SLOTW'(1), sp: SP_TOP, pend_save: 1'b0};
            for (int i = 0; i < DEPTH; i++)      phys_q[i] <= '0;
            for (int i = 0; i < GROUP_REGS; i++) glob_q[i] <= '0;
        end else begin
            st_q   <= st_d;
            phys_q <= phys_d;
            glob_q <= glob_d;
        end
    end

    // R6: resident count stays inside the ring capacity
    p_res_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.res >= SLOTW'(1)) && (st_q.res <= SLOTW'(MAXRES)));

    // R6: a completed spill lowers the stack pointer by one frame
    p_spill_sp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && st_q.pend_save) |=> (st_q.sp == $past(st_q.sp) - AW'(FRAME_WORDS)));

    // R7: a completed fill raises the stack pointer by one frame
    p_fill_sp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !st_q.pend_save) |=> (st_q.sp == $past(st_q.sp) + AW'(FRAME_WORDS)));

    // R4: a save without a transfer advances the window at once
    p_save_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && save_req && (st_q.res != SLOTW'(MAXRES)))
        |=> (!stall && (st_q.cwp == slot_inc($past(st_q.cwp)))));

    // R9: stall only starts from a command
    p_stall_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall) |-> $past(save_req || restore_req));

    // R9: the window does not move in the middle of a transfer
    p_cwp_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(st_q.cwp));

endmodule

// File: tb/win_regfile_tb_top.sv
`timescale 1ns/1ps
module win_regfile_tb_top;

    localparam int          NF   = 4;
    localparam int          XL   = 32;
    localparam int          AW   = 16;
    localparam logic [15:0] SPT  = 16'h0400;
    localparam int          MAXD = 24;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [4:0]    rs1_addr, rs2_addr, wr_addr;
    logic [XL-1:0] rs1_data, rs2_data, wr_data;
    logic          wr_en, save_req, restore_req, stall;
    logic          mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [XL-1:0] mem_wdata, mem_rdata;

    win_regfile #(.XLEN(XL), .NFRAMES(NF), .AW(AW), .SP_TOP(SPT)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .rs1_addr(rs1_addr), .rs1_data(rs1_data),
        .rs2_addr(rs2_addr), .rs2_data(rs2_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .save_req(save_req), .restore_req(restore_req), .stall(stall),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int  checks = 0, errors = 0;
    bit  reported = 0;

    // Architectural model: a stack of windows
    logic [31:0] mglob [8];
    logic [31:0] mloc  [MAXD+2][8];
    logic [31:0] mins  [MAXD+2][8];
    int          cur, mres;
    logic [15:0] msp;

    // Memory responder
    logic [31:0] mem [1024];
    int  wr_acks = 0, rd_acks = 0, ack_cyc = 0, wait_cnt = 0;
    bit  prev_pend = 0;
    logic [AW-1:0] prev_addr;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack   = 1'b0;
            wait_cnt  = 0;
            prev_pend = 0;
        end else if (mem_ack) begin
            mem_ack   = 1'b0;
            wait_cnt  = $urandom_range(0, 2);
            prev_pend = 0;
        end else if (mem_req) begin
            if (prev_pend) chk("R8", 32'(mem_addr), 32'(prev_addr), "address held while waiting");
            if (wait_cnt == 0) begin
                mem_ack = 1'b1;
                ack_cyc = cyc;
                if (mem_we) begin
                    mem[mem_addr[9:0]] = mem_wdata;
                    wr_acks++;
                end else begin
                    mem_rdata = mem[mem_addr[9:0]];
                    rd_acks++;
                end
                prev_pend = 0;
            end else begin
                wait_cnt--;
                prev_pend = 1;
            end
            prev_addr = mem_addr;
        end else begin
            prev_pend = 0;
        end
    end

    function automatic logic [31:0] exp_reg(input int r);
        if (r == 0)       return 32'h0;
        else if (r < 8)   return mglob[r];
        else if (r < 16)  return mloc[cur][r-8];
        else if (r < 24)  return mins[cur][r-16];
        else              return mins[cur+1][r-24];
    endfunction

    task automatic check_all(input string req);
        for (int r = 0; r < 32; r++) begin
            rs1_addr = 5'(r);
            rs2_addr = 5'(31 - r);
            #1;
            chk(req, rs1_data, exp_reg(r), $sformatf("port1 reg %0d", r));
            chk(req, rs2_data, exp_reg(31 - r), $sformatf("port2 reg %0d", 31 - r));
        end
    endtask

    task automatic do_write(input int r, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(r); wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        if (r != 0) begin
            if (r < 8)       mglob[r] = v;
            else if (r < 16) mloc[cur][r-8] = v;
            else if (r < 24) mins[cur][r-16] = v;
            else             mins[cur+1][r-24] = v;
        end
    endtask

    task automatic ignored_pokes();
        // R9: stimulus during stall must have no effect
        wr_en = 1'b1; wr_addr = 5'd9; wr_data = 32'hDEAD_BEEF;
        save_req = 1'b1; restore_req = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; save_req = 1'b0; restore_req = 1'b0;
        while (stall) @(negedge clk);
        chk("R9", 32'(cyc), 32'(ack_cyc + 1), "stall release cycle");
    endtask

    task automatic do_save();
        bit xfer;
        int sd, w0;
        xfer = (mres == NF - 1);
        sd   = cur - (NF - 2);
        w0   = wr_acks;
        @(negedge clk); save_req = 1'b1;
        @(negedge clk); save_req = 1'b0;
        if (xfer) begin
            chk("R9", 32'(stall), 32'h1, "stall after spilling save");
            ignored_pokes();
            msp = msp - 16'd16;
            chk("R6", 32'(wr_acks - w0), 32'd16, "spill word count");
            for (int k = 0; k < 8; k++) begin
                chk("R6", mem[msp[9:0] + 10'(k)], mloc[sd][k], $sformatf("spilled local %0d", k));
                chk("R6", mem[msp[9:0] + 10'(8 + k)], mins[sd][k], $sformatf("spilled input %0d", k));
            end
        end else begin
            chk("R4", 32'(stall), 32'h0, "no stall on free save");
            mres++;
        end
        cur++;
        for (int k = 0; k < 8; k++) begin
            mloc[cur][k]   = 32'h0;
            mins[cur+1][k] = 32'h0;
        end
    endtask

    task automatic do_restore();
        bit xfer;
        int r0;
        xfer = (mres == 1);
        r0   = rd_acks;
        @(negedge clk); restore_req = 1'b1;
        @(negedge clk); restore_req = 1'b0;
        if (xfer) begin
            chk("R9", 32'(stall), 32'h1, "stall after filling restore");
            ignored_pokes();
            msp = msp + 16'd16;
            chk("R7", 32'(rd_acks - r0), 32'd16, "fill word count");
        end else begin
            chk("R5", 32'(stall), 32'h0, "no stall on resident restore");
            mres--;
        end
        for (int k = 0; k < 8; k++) mloc[cur][k] = 32'h0;
        cur--;
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; wr_en = 0; wr_addr = 0; wr_data = 0;
        save_req = 0; restore_req = 0; rs1_addr = 0; rs2_addr = 0;
        mem_rdata = '0;
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        for (int i = 0; i < 8; i++) mglob[i] = 0;
        for (int d = 0; d < MAXD + 2; d++)
            for (int k = 0; k < 8; k++) begin
                mloc[d][k] = 0;
                mins[d][k] = 0;
            end
        cur = 0; mres = 1; msp = SPT;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        chk("R9", 32'(stall), 32'h0, "stall after reset");
        chk("R8", 32'(mem_req), 32'h0, "mem_req after reset");
        check_all("R1");

        // Register 0 and the shared group
        do_write(0, 32'hFFFF_FFFF);
        for (int g = 1; g < 8; g++) do_write(g, 32'h1000_0000 + 32'(g));
        check_all("R2");

        // Group mapping
        for (int r = 8; r < 32; r++) do_write(r, 32'hA000_0000 + 32'(r));
        check_all("R1");

        // Save: outputs become inputs, fresh locals and outputs
        do_save();
        check_all("R4");
        for (int r = 8; r < 32; r++) do_write(r, 32'hB000_0000 + 32'(r));
        do_restore();
        check_all("R5");

        // Deep calls force spills
        for (int d = 0; d < 10; d++) begin
            for (int r = 8; r < 32; r += 3) do_write(r, $urandom);
            do_save();
            check_all("R6");
        end
        // Unwind forces fills
        while (cur > 0) begin
            do_restore();
            check_all("R7");
        end
        check_all("R3");

        // Random mix
        for (int n = 0; n < 400; n++) begin
            int op;
            op = $urandom_range(0, 3);
            if (op <= 1) begin
                do_write($urandom_range(0, 31), $urandom);
            end else if (op == 2 && cur < MAXD - 1) begin
                do_save();
                check_all("R4");
            end else if (cur > 0) begin
                do_restore();
                check_all("R5");
            end
        end
        check_all("R3");

        report();
        $finish;
    end

endmodule